// File: doc/BRIEF.md
# Strobe-Based Rail Power Sequencer

This block switches a group of supply rails on and off as an ordered series of strobes. Each rail holds a small strobe number, and the gap between two neighbouring strobes is taken from a programmable delay. When a start request arrives, strobes fire from the lowest number to the highest. Each strobe sets the enable bit of every rail that carries that strobe number. When a stop request arrives, the same strobes fire from the highest number to the lowest and clear those bits. The gaps are the same, walked backwards.

The enable bits form one register that software and the sequencer share. Software may write it at any time except while a sequence is running, and it always shows the live rail state. A rail whose strobe number is not a valid slot is never touched by a sequence. A millisecond time base is derived from the system clock by a prescaler whose length is a parameter.

Top module: `rsq_sequencer`

## Requirements
- R1: After reset, `busy_o` is 0, every `rail_en_o` bit is 0, and every register reads back as 0.
- R2: A start request accepted while idle sets the enable bit of every rail assigned to strobe 1 on that same clock edge, and `busy_o` is 1 from the next cycle. During a power-up, enable bits are only ever set.
- R3: The strobe after strobe k fires exactly `ms(k) * TICK_CYCLES` clock cycles after strobe k. Here `ms(k)` is taken from the 2-bit delay of step k at address 8+k-1 (k = 1..6), with code 0 meaning 2 ms, 1 meaning 5 ms, 2 meaning 10 ms and 3 meaning 20 ms.
- R4: `busy_o` falls on the clock edge on which the last strobe of a sequence fires: strobe 7 for power-up, strobe 1 for power-down.
- R5: A stop request accepted while idle clears the rails of strobe 7 on that edge, then walks down to strobe 1. The gap between strobe k+1 and strobe k uses the delay of step k. During a power-down, enable bits are only ever cleared.
- R6: A rail whose 4-bit strobe field is 0, or is 8 to 15, keeps its enable state through both power-up and power-down.
- R7: A write to the enable register (address 14, bit n = rail n) while idle takes effect on the next edge. The write is refused while `busy_o` is 1, and also in a cycle in which a start or stop request is accepted.
- R8: A start or stop request while `busy_o` is 1 has no effect. If start and stop arrive together while idle, start wins and a power-up runs.
- R9: Read data is combinational from the address. Addresses 0 to 7 give rail n's strobe field in bits 3:0. Addresses 8 to 13 give the step delays in bits 1:0. Address 14 gives the live enable bits. Address 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Power-up request |
| stop_i | input | 1 | Power-down request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| busy_o | output | 1 | A sequence is running |
| rail_en_o | output | 8 | Live rail enable bits |

## Verification
The bench sets delays that differ step by step. A design that counts a gap from the wrong delay register, or is one prescaler period long or short, then shows a rail edge in the wrong cycle. The bench places rails on strobe codes 0 and 9 with opposite starting states. A design that decodes codes above 7 as valid slots would switch a rail that must not move. The bench sends an enable write, a start and a stop in the middle of a sequence. A design that does not lock these out would either corrupt the shared enable bits or restart the walk. The bench also sends start and stop together, and a stop together with an enable write. These catch a wrong priority between requests and a write slipping through on the cycle a sequence begins.

// File: rtl/rsq_pkg.sv
// Shared definitions for the rail sequencer.
// Assumes delay codes are two bits wide and map to millisecond counts.
package rsq_pkg;
    localparam int DLY_CODE_W = 2;
    localparam int MS_W       = 5;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Convert a delay code into its length in milliseconds.
    function automatic logic [MS_W-1:0] dly_ms(input logic [DLY_CODE_W-1:0] code);
        case (code)
            2'd0:    return 5'd2;
            2'd1:    return 5'd5;
            2'd2:    return 5'd10;
            default: return 5'd20;
        endcase
    endfunction
endpackage

// File: rtl/rsq_regs.sv
// Register store: per-rail strobe fields, per-step delays and the shared
// enable bits. Assumes NUM_RAILS >= SEL_W so every field fits the read word.
module rsq_regs #(
    parameter int NUM_RAILS   = 8,
    parameter int NUM_STROBES = 7,
    parameter int SEL_W       = 4,
    parameter int ADDR_W      = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_i,
    input  logic [ADDR_W-1:0]                            addr_i,
    input  logic [NUM_RAILS-1:0]                         wdata_i,
    input  logic                                         en_wr_ok_i,
    input  logic [NUM_RAILS-1:0]                         set_i,
    input  logic [NUM_RAILS-1:0]                         clr_i,
    output logic [NUM_RAILS-1:0]                         rdata_o,
    output logic [NUM_RAILS*SEL_W-1:0]                   fld_o,
    output logic [(NUM_STROBES-1)*rsq_pkg::DLY_CODE_W-1:0] dly_o,
    output logic [NUM_RAILS-1:0]                         en_o
);
    localparam int DW       = rsq_pkg::DLY_CODE_W;
    localparam int NSTEP    = NUM_STROBES - 1;
    localparam int DLY_BASE = NUM_RAILS;
    localparam int EN_ADDR  = NUM_RAILS + NSTEP;

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_fld
        // Hold the strobe number of rail r.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_o[r*SEL_W +: SEL_W] <= '0;
            else if (wr_i && addr_i == ADDR_W'(r))
                fld_o[r*SEL_W +: SEL_W] <= wdata_i[SEL_W-1:0];
        end
    end

    for (genvar s = 0; s < NSTEP; s++) begin : g_dly
        // Hold the delay code of step s+1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dly_o[s*DW +: DW] <= '0;
            else if (wr_i && addr_i == ADDR_W'(DLY_BASE + s))
                dly_o[s*DW +: DW] <= wdata_i[DW-1:0];
        end
    end

    // Shared enable bits: software write when allowed, else sequencer set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i && addr_i == ADDR_W'(EN_ADDR) && en_wr_ok_i)
            en_o <= wdata_i;
        else
            en_o <= (en_o | set_i) & ~clr_i;
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NUM_RAILS; r++)
            if (addr_i == ADDR_W'(r)) rdata_o = NUM_RAILS'(fld_o[r*SEL_W +: SEL_W]);
        for (int s = 0; s < NSTEP; s++)
            if (addr_i == ADDR_W'(DLY_BASE + s)) rdata_o = NUM_RAILS'(dly_o[s*DW +: DW]);
        if (addr_i == ADDR_W'(EN_ADDR)) rdata_o = en_o;
    end
endmodule

// File: rtl/rsq_timer.sv
// Gap timer: a prescaler makes a millisecond tick, a counter counts ticks.
// done_o pulses in the last cycle of target_i milliseconds.
// Assumes TICK_CYCLES >= 2 and target_i >= 1.
module rsq_timer #(
    parameter int TICK_CYCLES = 50000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     restart_i,
    input  logic [rsq_pkg::MS_W-1:0] target_i,
    output logic                     done_o
);
    localparam int PW = $clog2(TICK_CYCLES);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0]            presc_q;
    logic [rsq_pkg::MS_W-1:0] ms_q;
    logic                     tick;

    assign tick   = (presc_q == PRE_LAST);
    assign done_o = run_i && tick && (ms_q == target_i - 1'b1);

    // Count cycles and milliseconds since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) begin
            presc_q <= '0;
            ms_q    <= '0;
        end else if (tick) begin
            presc_q <= '0;
            ms_q    <= ms_q + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsq_ctrl.sv
// Sequence controller: accepts start/stop while idle, walks the strobe
// number up or down on each timer expiry and returns to idle after the
// last strobe. Start has priority over stop. Assumes NUM_STROBES >= 2.
module rsq_ctrl #(
    parameter int NUM_STROBES = 7,
    parameter int STB_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tmr_done_i,
    output logic             busy_o,
    output logic             dir_up_o,
    output logic [STB_W-1:0] cur_o,
    output logic             fire_o,
    output logic             fire_up_o,
    output logic [STB_W-1:0] fire_stb_o
);
    import rsq_pkg::*;

    localparam logic [STB_W-1:0] STB_FIRST = STB_W'(1);
    localparam logic [STB_W-1:0] STB_LAST  = STB_W'(NUM_STROBES);

    seq_state_e       state_q, state_d;
    logic             dir_d;
    logic [STB_W-1:0] cur_d;

    assign busy_o = (state_q == SEQ_RUN);

    // Decide whether a strobe fires this cycle and which one.
    always_comb begin
        state_d    = state_q;
        dir_d      = dir_up_o;
        cur_d      = cur_o;
        fire_o     = 1'b0;
        fire_up_o  = dir_up_o;
        fire_stb_o = cur_o;
        if (state_q == SEQ_IDLE) begin
            if (start_i || stop_i) begin
                fire_o     = 1'b1;
                fire_up_o  = start_i;
                fire_stb_o = start_i ? STB_FIRST : STB_LAST;
                dir_d      = start_i;
                cur_d      = fire_stb_o;
                state_d    = SEQ_RUN;
            end
        end else if (tmr_done_i) begin
            fire_o     = 1'b1;
            fire_stb_o = dir_up_o ? cur_o + 1'b1 : cur_o - 1'b1;
            cur_d      = fire_stb_o;
            if (fire_stb_o == (dir_up_o ? STB_LAST : STB_FIRST))
                state_d = SEQ_IDLE;
        end
    end

    // State, direction and current strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            dir_up_o <= 1'b1;
            cur_o    <= '0;
        end else begin
            state_q  <= state_d;
            dir_up_o <= dir_d;
            cur_o    <= cur_d;
        end
    end
endmodule

// File: rtl/rsq_sequencer.sv
// Top of the rail sequencer: ties registers, controller and timer together
// and turns each fired strobe into per-rail set or clear masks.
// Assumes NUM_STROBES >= 2, TICK_CYCLES >= 2 and NUM_RAILS >= SEL_W.
module rsq_sequencer #(
    parameter int NUM_RAILS   = 8,
    parameter int NUM_STROBES = 7,
    parameter int SEL_W       = 4,
    parameter int TICK_CYCLES = 50000,
    parameter int ADDR_W      = $clog2(NUM_RAILS + NUM_STROBES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [NUM_RAILS-1:0] reg_wdata_i,
    output logic [NUM_RAILS-1:0] reg_rdata_o,
    output logic                 busy_o,
    output logic [NUM_RAILS-1:0] rail_en_o
);
    import rsq_pkg::*;

    localparam int STB_W = $clog2(NUM_STROBES + 1);
    localparam int NSTEP = NUM_STROBES - 1;
    localparam int DW    = DLY_CODE_W;

    logic [NUM_RAILS*SEL_W-1:0] fld_flat;
    logic [NSTEP*DW-1:0]        dly_flat;
    logic [NUM_RAILS-1:0]       set_mask, clr_mask;
    logic                       fire, fire_up, dir_up, tmr_done;
    logic [STB_W-1:0]           fire_stb, cur, step_idx;
    logic [MS_W-1:0]            tgt_ms;

    rsq_regs #(
        .NUM_RAILS(NUM_RAILS), .NUM_STROBES(NUM_STROBES),
        .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .en_wr_ok_i(!busy_o && !fire),
        .set_i(set_mask), .clr_i(clr_mask),
        .rdata_o(reg_rdata_o), .fld_o(fld_flat), .dly_o(dly_flat),
        .en_o(rail_en_o)
    );

    rsq_ctrl #(.NUM_STROBES(NUM_STROBES), .STB_W(STB_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .stop_i(stop_i), .tmr_done_i(tmr_done),
        .busy_o(busy_o), .dir_up_o(dir_up), .cur_o(cur),
        .fire_o(fire), .fire_up_o(fire_up), .fire_stb_o(fire_stb)
    );

    rsq_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run_i(busy_o), .restart_i(fire),
        .target_i(tgt_ms), .done_o(tmr_done)
    );

    // Step k lies between strobes k and k+1 (zero-based index k-1).
    assign step_idx = dir_up ? cur - STB_W'(1) : cur - STB_W'(2);

    // Pick the delay of the step now being timed.
    always_comb begin
        tgt_ms = dly_ms('0);
        for (int s = 0; s < NSTEP; s++)
            if (step_idx == STB_W'(s)) tgt_ms = dly_ms(dly_flat[s*DW +: DW]);
    end

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_mask
        logic hit;
        // A rail reacts only when its field equals the strobe firing now.
        assign hit         = fire && (fld_flat[r*SEL_W +: SEL_W] == SEL_W'(fire_stb));
        assign set_mask[r] = hit && fire_up;
        assign clr_mask[r] = hit && !fire_up;
    end
endmodule

// File: rtl/rsq_sequencer_chk.sv
// Property checker for rsq_sequencer, attached with bind below.
// Observes the ports plus the controller's direction and strobe counter.
module rsq_sequencer_chk #(
    parameter int NUM_RAILS   = 8,
    parameter int NUM_STROBES = 7,
    parameter int SEL_W       = 4,
    parameter int STB_W       = 3,
    parameter int ADDR_W      = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       stop_i,
    input logic                       reg_wr_i,
    input logic [ADDR_W-1:0]          reg_addr_i,
    input logic                       busy_o,
    input logic [NUM_RAILS-1:0]       rail_en_o,
    input logic                       dir_up,
    input logic [STB_W-1:0]           cur,
    input logic [NUM_RAILS*SEL_W-1:0] fld_flat
);
    localparam int EN_ADDR = NUM_RAILS + NUM_STROBES - 1;

    logic [NUM_RAILS-1:0] unas;
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_unas
        assign unas[r] = (fld_flat[r*SEL_W +: SEL_W] == '0) ||
                         (fld_flat[r*SEL_W +: SEL_W] > SEL_W'(NUM_STROBES));
    end

    a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && dir_up));

    a_r5_stop_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && stop_i) |=> (busy_o && !dir_up));

    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && stop_i) |=> dir_up);

    a_r2_up_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dir_up) |=> ((rail_en_o & $past(rail_en_o)) == $past(rail_en_o)));

    a_r5_down_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !dir_up) |=> ((rail_en_o | $past(rail_en_o)) == $past(rail_en_o)));

    a_r6_unassigned_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((rail_en_o & $past(unas)) == ($past(rail_en_o) & $past(unas))));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !stop_i &&
         !(reg_wr_i && reg_addr_i == ADDR_W'(EN_ADDR))) |=> $stable(rail_en_o));

    a_r4_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cur >= STB_W'(1) && cur <= STB_W'(NUM_STROBES)));
endmodule

bind rsq_sequencer rsq_sequencer_chk #(
    .NUM_RAILS(NUM_RAILS), .NUM_STROBES(NUM_STROBES),
    .SEL_W(SEL_W), .STB_W(STB_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .busy_o(busy_o), .rail_en_o(rail_en_o),
    .dir_up(dir_up), .cur(cur), .fld_flat(fld_flat)
);

// File: tb/test_rsq_sequencer.sv
// Bench for rsq_sequencer: a behavioural countdown model compared every cycle.
module test_rsq_sequencer;
    localparam int NR   = 8;
    localparam int NS   = 7;
    localparam int TICK = 4;
    localparam int ENA  = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, reg_wr_i = 1'b0;
    logic [3:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o, rail_en_o;
    logic       busy_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";

    rsq_sequencer #(.TICK_CYCLES(TICK)) i_rsq_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .busy_o(busy_o), .rail_en_o(rail_en_o)
    );

    always #10 clk = ~clk;

    // Reference model state.
    logic [7:0] m_en;
    logic       m_busy, m_up;
    int         m_cur, m_cnt;
    int         m_fld[NR];
    int         m_dly[NS-1];

    function automatic int gap(input int code);
        int ms;
        ms = (code == 0) ? 2 : (code == 1) ? 5 : (code == 2) ? 10 : 20;
        return ms * TICK;
    endfunction

    task automatic apply_strobe(input int k, input logic up);
        for (int r = 0; r < NR; r++) if (m_fld[r] == k) m_en[r] = up;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_busy = 0; m_up = 1; m_cur = 0; m_cnt = 0;
            for (int r = 0; r < NR; r++) m_fld[r] = 0;
            for (int s = 0; s < NS-1; s++) m_dly[s] = 0;
        end else begin
            logic acc_s, acc_p;
            acc_s = !m_busy && start_i;
            acc_p = !m_busy && !start_i && stop_i;
            if (acc_s) begin
                m_up = 1; m_cur = 1; apply_strobe(1, 1'b1);
                m_busy = 1; m_cnt = gap(m_dly[0]);
            end else if (acc_p) begin
                m_up = 0; m_cur = NS; apply_strobe(NS, 1'b0);
                m_busy = 1; m_cnt = gap(m_dly[NS-2]);
            end else if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_cur = m_up ? m_cur + 1 : m_cur - 1;
                    apply_strobe(m_cur, m_up);
                    if ((m_up && m_cur == NS) || (!m_up && m_cur == 1)) m_busy = 0;
                    else m_cnt = gap(m_dly[m_up ? m_cur - 1 : m_cur - 2]);
                end
            end else if (reg_wr_i && reg_addr_i == 4'(ENA)) begin
                m_en = reg_wdata_i;
            end
            if (reg_wr_i && reg_addr_i < 4'(NR)) m_fld[reg_addr_i] = int'(reg_wdata_i[3:0]);
            if (reg_wr_i && reg_addr_i >= 4'(NR) && reg_addr_i < 4'(ENA))
                m_dly[reg_addr_i - 4'(NR)] = int'(reg_wdata_i[1:0]);
        end
    end

    // Compare outputs to the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (busy_o !== m_busy || rail_en_o !== m_en) begin
                n_fail++;
                $display("FAIL %s cycle %0d: busy=%b en=%h expected busy=%b en=%h",
                         cur_req, cyc, busy_o, rail_en_o, m_busy, m_en);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = 8'(d);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        reg_addr_i = 4'(a);
        #1;
        chk(req, reg_rdata_o, 8'(exp));
    endtask

    task automatic pulse(input logic s, input logic p, input logic w, input int d);
        @(negedge clk);
        start_i = s; stop_i = p; reg_wr_i = w; reg_addr_i = 4'(ENA); reg_wdata_i = 8'(d);
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0; reg_wr_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1", {7'd0, busy_o}, 8'h00);
        chk("R1", rail_en_o, 8'h00);
        rd_chk("R1", 0, 0);
        rd_chk("R1", ENA, 0);
        rst_n = 1'b1;

        // Program strobe fields and step delays.
        cur_req = "R9";
        wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 0);
        wr(4, 7); wr(5, 9); wr(6, 4); wr(7, 1);
        wr(8, 0); wr(9, 1); wr(10, 2); wr(11, 3); wr(12, 0); wr(13, 1);
        rd_chk("R9", 5, 9);
        rd_chk("R9", 11, 3);
        rd_chk("R9", 15, 0);

        // R7: software enable write while idle.
        cur_req = "R7";
        wr(ENA, 8'h08);
        chk("R7", rail_en_o, 8'h08);

        // R2/R3/R4: power-up with refused write and ignored requests mid-run.
        cur_req = "R2";
        pulse(1'b1, 1'b0, 1'b0, 0);
        chk("R2", rail_en_o, 8'h89);
        cur_req = "R3";
        repeat (12) @(negedge clk);
        cur_req = "R7";
        wr(ENA, 8'h00);
        cur_req = "R8";
        pulse(1'b1, 1'b0, 1'b0, 0);
        pulse(1'b0, 1'b1, 1'b0, 0);
        cur_req = "R4";
        wait_idle();
        chk("R6", rail_en_o, 8'hDF);
        rd_chk("R9", ENA, 8'hDF);

        // R5: power-down, with a start request ignored mid-run.
        cur_req = "R5";
        pulse(1'b0, 1'b1, 1'b0, 0);
        repeat (30) @(negedge clk);
        cur_req = "R8";
        pulse(1'b1, 1'b0, 1'b0, 0);
        cur_req = "R5";
        wait_idle();
        chk("R6", rail_en_o, 8'h08);

        // R6: unassigned rails keep their software state through power-up.
        cur_req = "R6";
        wr(ENA, 8'h20);
        pulse(1'b1, 1'b0, 1'b0, 0);
        wait_idle();
        chk("R6", rail_en_o, 8'hF7);

        // R8: start and stop together while idle, start wins.
        cur_req = "R8";
        pulse(1'b1, 1'b1, 1'b0, 0);
        chk("R8", {7'd0, busy_o}, 8'h01);
        wait_idle();
        chk("R8", rail_en_o, 8'hF7);

        // R7: enable write in the cycle a stop is accepted is refused.
        cur_req = "R7";
        pulse(1'b0, 1'b1, 1'b1, 8'h00);
        wait_idle();
        chk("R7", rail_en_o, 8'h20);

        finish_run();
    end
endmodule